// File: doc/BRIEF.md
# Call and Interrupt Stack Controller

This block manages the return stack of a small 4-bit processor. It holds an 8-bit stack pointer that is always even. On a call or interrupt request it saves a frame into data memory bank 0. The frame carries the 15-bit program counter, one frame-kind bit and the 16-bit status word. On a return request it reads the frame back and presents the saved values. Software can also load the pointer and read it.

The memory port is one nibble wide and accesses one nibble per cycle. A frame is eight nibbles. The bank field of the address is fixed, so there is no gate on stack traffic and an enable flag elsewhere cannot block it. The pointer pre-decrements on a push and wraps modulo 256. From a pointer of 00H, the first nibble is therefore written at 0FFH. Memory reads are synchronous: data returns in the cycle after the read strobe.

Requests arrive on `req_op` and are taken only when the unit is idle. The encodings are 0 none, 1 call, 2 interrupt, 3 return, 4 pointer write and 5 pointer read; 6 and 7 do nothing. The sequencer has four states:
- IDLE accepts a request.
- PUSH (8 cycles) writes the frame and then returns to IDLE.
- POP_RD (8 cycles) issues the reads and then moves to POP_LAST.
- POP_LAST (1 cycle) captures the final nibble, updates the pointer and returns to IDLE.

Top module: `stack_unit`

## Requirements
- R1: A pointer write (op 4) in IDLE loads `sp_wdata` at the accepting edge. A pointer read (op 5) presents the pointer on `sp_rdata`, with `sp_rd_valid` high, in the cycle after acceptance.
- R2: Bit 0 of the pointer is always 0. Bit 0 of `sp_wdata` is ignored, so a write of 37H reads back as 36H.
- R3: A call (op 1) or interrupt (op 2) writes eight nibbles in the eight cycles after acceptance, one per cycle.
  - Nibble k (k = 0..7) goes to address SP−1−k.
  - The frame is the 32-bit value {kind, PC[14:0], PSW[15:0]}, and nibble k is frame bits [31−4k : 28−4k].
- R4: Every stack access drives `mem_addr[11:8]` = 0 (bank 0).
- R5: After a push the pointer equals the old SP−8 modulo 256. From 00H the first write lands at 0FFH and the pointer becomes F8H.
- R6: A return (op 3) issues eight reads at SP, SP+1, … SP+7, one per cycle, in the eight cycles after acceptance. In the tenth cycle after acceptance, `ret_valid` is high for one cycle with `pc_out`/`psw_out` restored. The pointer becomes SP+8 modulo 256.
- R7: `busy` is high for 8 cycles on a push and 9 cycles on a pop, starting the cycle after acceptance. Any request presented while `busy` is high has no effect.
- R8: The frame-kind bit is 0 for a call and 1 for an interrupt. On return it appears on `ret_is_int`.
- R9: While reset is held, `busy`, `mem_we`, `mem_re`, `ret_valid` and `sp_rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_op | input | 3 | Request code, sampled when idle |
| sp_wdata | input | 8 | New pointer value for a pointer write |
| pc_in | input | 15 | Program counter to save |
| psw_in | input | 16 | Status word to save |
| pc_out | output | 15 | Restored program counter |
| psw_out | output | 16 | Restored status word |
| ret_valid | output | 1 | One-cycle pulse when a restore completes |
| ret_is_int | output | 1 | Restored frame came from an interrupt |
| sp_rdata | output | 8 | Pointer value from the last pointer read |
| sp_rd_valid | output | 1 | One-cycle pulse for a pointer read |
| busy | output | 1 | Frame transfer in progress |
| mem_we | output | 1 | Stack memory write strobe |
| mem_re | output | 1 | Stack memory read strobe |
| mem_addr | output | 12 | Stack memory address {bank, offset} |
| mem_wdata | output | 4 | Nibble to write |
| mem_rdata | input | 4 | Nibble read, valid the cycle after `mem_re` |

## Verification
The bench drives each request on a falling edge, so the unit accepts it at the next rising edge. It then samples results on falling edges:
- Pointer-read data is checked one cycle after acceptance.
- Write and read strobes are logged on every falling edge while `busy` is high. This gives 8 entries per transfer, starting the cycle after acceptance.
- Restored values are checked in the tenth cycle after a return, when `busy` has just dropped.

The number of busy cycles is counted and compared with 8 for a push and 9 for a pop. Requests injected during `busy` are followed by a pointer read and a strobe count, to show they left no trace.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_CALL = 3'd1,
        OP_INT  = 3'd2,
        OP_RET  = 3'd3,
        OP_SPWR = 3'd4,
        OP_SPRD = 3'd5
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_POP_RD,
        ST_POP_LAST
    } stk_state_e;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int SP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld,
    input  logic [SP_W-1:0] ld_val,
    input  logic            upd,
    input  logic [SP_W-1:0] upd_val,
    input  logic            rd,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] sp_rdata,
    output logic            sp_rd_valid
);
    localparam logic [SP_W-1:0] EVEN_MASK = ~SP_W'(1);

    logic [SP_W-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q        <= '0;
            sp_rdata    <= '0;
            sp_rd_valid <= 1'b0;
        end else begin
            if (ld)
                sp_q <= ld_val & EVEN_MASK;
            else if (upd)
                sp_q <= upd_val & EVEN_MASK;
            sp_rd_valid <= rd;
            if (rd)
                sp_rdata <= sp_q;
        end
    end

    assign sp = sp_q;
endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter int SP_W = 8,
    parameter int NIBS = 8,
    parameter int CNT_W = $clog2(NIBS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       req_op,
    input  logic [SP_W-1:0]  sp,
    output logic             busy,
    output logic             wr_en,
    output logic             rd_en,
    output logic [CNT_W-1:0] cnt,
    output logic [SP_W-1:0]  addr,
    output logic             sp_ld,
    output logic             sp_upd,
    output logic [SP_W-1:0]  sp_upd_val,
    output logic             sp_rd,
    output logic             launch,
    output logic             launch_int,
    output logic             pop_done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NIBS - 1);

    stk_state_e      state;
    logic [SP_W-1:0] base;
    stk_op_e         op;

    assign op = stk_op_e'(req_op);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            base  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt  <= '0;
                    base <= sp;
                    if (op == OP_CALL || op == OP_INT)
                        state <= ST_PUSH;
                    else if (op == OP_RET)
                        state <= ST_POP_RD;
                end
                ST_PUSH: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST)
                        state <= ST_IDLE;
                end
                ST_POP_RD: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST)
                        state <= ST_POP_LAST;
                end
                ST_POP_LAST: state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = 1'b0;
        wr_en      = 1'b0;
        rd_en      = 1'b0;
        addr       = base;
        sp_ld      = 1'b0;
        sp_upd     = 1'b0;
        sp_upd_val = base;
        sp_rd      = 1'b0;
        launch     = 1'b0;
        launch_int = 1'b0;
        pop_done   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                sp_ld      = (op == OP_SPWR);
                sp_rd      = (op == OP_SPRD);
                launch     = (op == OP_CALL) || (op == OP_INT);
                launch_int = (op == OP_INT);
            end
            ST_PUSH: begin
                busy  = 1'b1;
                wr_en = 1'b1;
                addr  = base - SP_W'(1) - SP_W'(cnt);
                if (cnt == LAST) begin
                    sp_upd     = 1'b1;
                    sp_upd_val = base - SP_W'(NIBS);
                end
            end
            ST_POP_RD: begin
                busy  = 1'b1;
                rd_en = 1'b1;
                addr  = base + SP_W'(cnt);
            end
            ST_POP_LAST: begin
                busy       = 1'b1;
                sp_upd     = 1'b1;
                sp_upd_val = base + SP_W'(NIBS);
                pop_done   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/stk_frame.sv
module stk_frame #(
    parameter int PC_W  = 15,
    parameter int PSW_W = 16,
    parameter int NIBS  = 8,
    parameter int CNT_W = $clog2(NIBS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             launch_int,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [PSW_W-1:0] psw_in,
    input  logic [CNT_W-1:0] cnt,
    input  logic             rd_en,
    input  logic [3:0]       rdata,
    input  logic             pop_done,
    output logic [3:0]       wdata,
    output logic [PC_W-1:0]  pc_out,
    output logic [PSW_W-1:0] psw_out,
    output logic             ret_valid,
    output logic             ret_is_int
);
    localparam int FR_W = NIBS * 4;
    localparam int PAD  = FR_W - PC_W - PSW_W;

    logic [FR_W-1:0]  shadow;
    logic [3:0]       nib [NIBS];
    logic             cap_v;
    logic [CNT_W-1:0] cap_j;

    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        assign nib[g] = shadow[FR_W-1-4*g -: 4];
    end

    assign wdata = nib[cnt];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow     <= '0;
            cap_v      <= 1'b0;
            cap_j      <= '0;
            pc_out     <= '0;
            psw_out    <= '0;
            ret_valid  <= 1'b0;
            ret_is_int <= 1'b0;
        end else begin
            cap_v     <= rd_en;
            cap_j     <= cnt;
            ret_valid <= pop_done;
            if (launch)
                shadow <= {{PAD{launch_int}}, pc_in, psw_in};
            else if (cap_v)
                shadow[4*cap_j +: 4] <= rdata;
            if (pop_done) begin
                pc_out     <= {rdata[3-PAD:0], shadow[FR_W-5:PSW_W]};
                psw_out    <= shadow[PSW_W-1:0];
                ret_is_int <= rdata[3];
            end
        end
    end
endmodule

// File: rtl/stack_unit.sv
module stack_unit #(
    parameter int PC_W       = 15,
    parameter int PSW_W      = 16,
    parameter int SP_W       = 8,
    parameter int BANK_W     = 4,
    parameter int STACK_BANK = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           req_op,
    input  logic [SP_W-1:0]      sp_wdata,
    input  logic [PC_W-1:0]      pc_in,
    input  logic [PSW_W-1:0]     psw_in,
    output logic [PC_W-1:0]      pc_out,
    output logic [PSW_W-1:0]     psw_out,
    output logic                 ret_valid,
    output logic                 ret_is_int,
    output logic [SP_W-1:0]      sp_rdata,
    output logic                 sp_rd_valid,
    output logic                 busy,
    output logic                 mem_we,
    output logic                 mem_re,
    output logic [BANK_W+SP_W-1:0] mem_addr,
    output logic [3:0]           mem_wdata,
    input  logic [3:0]           mem_rdata
);
    localparam int NIBS  = (PC_W + 1 + 3) / 4 + (PSW_W + 3) / 4;
    localparam int CNT_W = $clog2(NIBS);

    logic [SP_W-1:0]  sp, sp_upd_val, addr;
    logic [CNT_W-1:0] cnt;
    logic             sp_ld, sp_upd, sp_rd, launch, launch_int, pop_done;

    stk_seq #(.SP_W(SP_W), .NIBS(NIBS), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_op(req_op), .sp(sp),
        .busy(busy), .wr_en(mem_we), .rd_en(mem_re), .cnt(cnt), .addr(addr),
        .sp_ld(sp_ld), .sp_upd(sp_upd), .sp_upd_val(sp_upd_val), .sp_rd(sp_rd),
        .launch(launch), .launch_int(launch_int), .pop_done(pop_done)
    );

    stk_ptr #(.SP_W(SP_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .ld(sp_ld), .ld_val(sp_wdata),
        .upd(sp_upd), .upd_val(sp_upd_val), .rd(sp_rd), .sp(sp),
        .sp_rdata(sp_rdata), .sp_rd_valid(sp_rd_valid)
    );

    stk_frame #(.PC_W(PC_W), .PSW_W(PSW_W), .NIBS(NIBS), .CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_int(launch_int),
        .pc_in(pc_in), .psw_in(psw_in), .cnt(cnt), .rd_en(mem_re),
        .rdata(mem_rdata), .pop_done(pop_done), .wdata(mem_wdata),
        .pc_out(pc_out), .psw_out(psw_out), .ret_valid(ret_valid),
        .ret_is_int(ret_is_int)
    );

    assign mem_addr = {BANK_W'(STACK_BANK), addr};
endmodule

// File: rtl/stack_unit_chk.sv
module stack_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mem_we,
    input logic        mem_re,
    input logic [11:0] mem_addr,
    input logic        ret_valid,
    input logic        sp_rd_valid,
    input logic [7:0]  sp_rdata
);
    AST_SP_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        sp_rd_valid |-> (sp_rdata[0] == 1'b0)); // R2
    AST_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (mem_addr[11:8] == 4'h0)); // R4
    AST_WR_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr[7:0] == $past(mem_addr[7:0]) - 8'd1)); // R3
    AST_RD_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr[7:0] == $past(mem_addr[7:0]) + 8'd1)); // R6
    AST_NO_WR_RD_MIX: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R7
    AST_ACCESS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> busy); // R7
    AST_RET_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> ($past(busy) && !busy)); // R6
    AST_RET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> !ret_valid); // R6
endmodule

bind stack_unit stack_unit_chk u_chk (.*);

// File: tb/stack_unit_tb.sv
module stack_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 4;
    // each entry is the expected frame {kind, pc[14:0], psw[15:0]}
    localparam logic [31:0] VEC [NV] = '{
        32'h7FFF0000, 32'h8000FFFF, 32'h2A5C3C96, 32'hD193A5E1
    };

    logic        clk = 0, rst_n = 0;
    logic [2:0]  req_op = 0;
    logic [7:0]  sp_wdata = 0;
    logic [14:0] pc_in = 0;
    logic [15:0] psw_in = 0;
    logic [14:0] pc_out;
    logic [15:0] psw_out;
    logic        ret_valid, ret_is_int, sp_rd_valid, busy, mem_we, mem_re;
    logic [7:0]  sp_rdata;
    logic [11:0] mem_addr;
    logic [3:0]  mem_wdata, mem_rdata;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [3:0] mem [256];
    logic [7:0] wa [16]; logic [3:0] wd [16]; int wcnt;
    logic [7:0] ra [16]; int rcnt;
    bit bank_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_unit u_dut (.*);

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end

    always @(negedge clk) begin
        if ((mem_we || mem_re) && mem_addr[11:8] != 4'h0) bank_bad = 1;
        if (mem_we && wcnt < 16) begin wa[wcnt] = mem_addr[7:0]; wd[wcnt] = mem_wdata; wcnt++; end
        if (mem_re && rcnt < 16) begin ra[rcnt] = mem_addr[7:0]; rcnt++; end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [7:0] wdv);
        @(negedge clk); req_op = op; sp_wdata = wdv;
        @(negedge clk); req_op = 0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    task automatic read_sp(input logic [7:0] exp, input string tag);
        issue(3'd5, 8'h00);
        check(sp_rd_valid == 1 && sp_rdata == exp, tag, {23'd0, sp_rd_valid, sp_rdata}, {24'd1, exp});
    endtask

    task automatic push(input logic [31:0] fr, input logic [7:0] sp0);
        int n;
        wcnt = 0; rcnt = 0; bank_bad = 0;
        pc_in = fr[30:16]; psw_in = fr[15:0];
        issue(fr[31] ? 3'd2 : 3'd1, 8'h00);
        wait_idle(n);
        check(n == 8, "R7 push busy cycles", n, 8);
        check(wcnt == 8 && rcnt == 0, "R3 push write count", wcnt, 8);
        for (int k = 0; k < 8; k++) begin
            check(wa[k] == 8'(sp0 - 8'd1 - 8'(k)), "R3 push address", wa[k], 8'(sp0 - 8'd1 - 8'(k)));
            check(wd[k] == fr[31-4*k -: 4], "R3 push nibble", wd[k], fr[31-4*k -: 4]);
        end
        check(!bank_bad, "R4 bank field", bank_bad, 0);
    endtask

    task automatic pop(input logic [31:0] fr, input logic [7:0] sp0);
        int n;
        wcnt = 0; rcnt = 0; bank_bad = 0;
        issue(3'd3, 8'h00);
        wait_idle(n);
        check(n == 9, "R7 pop busy cycles", n, 9);
        check(rcnt == 8 && wcnt == 0 && ra[0] == sp0 && ra[7] == 8'(sp0 + 8'd7),
              "R6 pop reads", {rcnt[7:0], ra[0], ra[7]}, {8'd8, sp0, 8'(sp0 + 8'd7)});
        check(ret_valid == 1, "R6 ret_valid timing", ret_valid, 1);
        check(pc_out == fr[30:16] && psw_out == fr[15:0], "R6 restored values",
              {1'b0, pc_out, psw_out}, {1'b0, fr[30:0]});
        check(ret_is_int == fr[31], "R8 frame kind", ret_is_int, fr[31]);
        check(!bank_bad, "R4 bank field", bank_bad, 0);
        @(negedge clk);
        check(ret_valid == 0, "R6 ret_valid one cycle", ret_valid, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(!busy && !mem_we && !mem_re && !ret_valid && !sp_rd_valid, "R9 reset outputs",
              {busy, mem_we, mem_re, ret_valid, sp_rd_valid}, 0);
        rst_n = 1;

        // R1 / R2: pointer write and read back
        issue(3'd4, 8'h37);
        read_sp(8'h36, "R2 bit0 dropped");
        issue(3'd4, 8'hA4);
        read_sp(8'hA4, "R1 pointer write/read");

        // table walk: pushes from 00H then pops in reverse
        issue(3'd4, 8'h00);
        for (int i = 0; i < NV; i++) begin
            push(VEC[i], 8'(0 - 8 * i));
            if (i == 0) check(wa[0] == 8'hFF, "R5 first write at FF", wa[0], 8'hFF);
            read_sp(8'(0 - 8 * (i + 1)), "R5 pointer after push");
        end
        for (int i = NV - 1; i >= 0; i--) begin
            pop(VEC[i], 8'(0 - 8 * (i + 1)));
            read_sp(8'(0 - 8 * i), "R6 pointer after pop");
        end

        // R7: requests while busy ignored
        issue(3'd4, 8'h40);
        wcnt = 0; rcnt = 0;
        pc_in = 15'h1111; psw_in = 16'h2222;
        issue(3'd1, 8'h00);
        req_op = 3'd4; sp_wdata = 8'h55; @(negedge clk);
        req_op = 3'd3; @(negedge clk);
        req_op = 3'd2; @(negedge clk);
        req_op = 0;
        wait_idle(n);
        check(wcnt == 8 && rcnt == 0, "R7 ignored while busy strobes", {wcnt[15:0], rcnt[15:0]}, {16'd8, 16'd0});
        read_sp(8'h38, "R7 ignored pointer write");
        pop({1'b0, 15'h1111, 16'h2222}, 8'h38);

        // R5 / R6 wrap through 00H
        issue(3'd4, 8'h04);
        push(VEC[2], 8'h04);
        check(wa[4] == 8'hFF, "R5 wrap address", wa[4], 8'hFF);
        read_sp(8'hFC, "R5 wrap pointer");
        pop(VEC[2], 8'hFC);
        read_sp(8'h04, "R6 wrap pointer restore");

        // unused op codes do nothing
        wcnt = 0; rcnt = 0;
        issue(3'd7, 8'h00);
        check(!busy && wcnt == 0 && rcnt == 0, "R7 unused code", {busy, wcnt[7:0]}, 0);
        read_sp(8'h04, "R1 pointer unchanged");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule